// File: doc/BRIEF.md
# Peripheral I/O Window Decoder

This block classifies each CPU access that falls in the 4 KB peripheral window at offsets $C000-$CFFF of banks $00, $01, $E0 and $E1. It decides whether the access targets the internal I/O space (soft switches and registers), the internal ROM, or plain RAM. It also produces the physical address that the memory system should use. The decoding of individual registers inside the I/O space is left to a downstream block.

Above the always-I/O page at $C0xx, the window is cut into four fixed slot ranges. Each range has its own enable flag. A set flag maps that range onto the topmost ROM bank at the same offset, and a clear flag leaves the range as I/O. A single inhibit input turns the whole window back into RAM in the two low banks. In that case bank $00 follows the auxiliary read and write selects, and bank $01 always goes to main RAM. The high banks ignore the inhibit. Requests are registered, and every result appears one clock after its request.

Top module: `io_window_dec`

## Requirements
- R1: During and right after reset, every output is 0.
- R2: In a window bank with the window not inhibited, an access to offsets $C000-$C0FF gives rsp_hit=1, rsp_io=1, rsp_rom=0 and rsp_addr equal to the request address.
- R3: The slot ranges are tied to enable bits as follows: bit 0 covers $C100-$C2FF, bit 1 covers $C300-$C3FF, bit 2 covers $C400-$C7FF and bit 3 covers $C800-$CFFF. When the bit for a range is 1, an access gives rsp_rom=1, rsp_io=0 and rsp_addr={ROM_TOP_BANK, offset}. When the bit is 0, it gives rsp_io=1, rsp_rom=0 and an unchanged address. rsp_io and rsp_rom are never both 1.
- R4: When io_inhibit=1, any access to $C000-$CFFF of bank $00 or $01 gives rsp_hit=1, rsp_io=0 and rsp_rom=0, whatever the slot enables are.
- R5: With the window inhibited, a bank $00 access is routed to physical bank $01 (auxiliary) when the select for its direction is 1 (aux_rd for reads, aux_wr for writes). Otherwise it goes to bank $00. The offset is kept.
- R6: With the window inhibited, a bank $01 access always goes to physical bank $00 (main) at the same offset, whatever aux_rd and aux_wr are.
- R7: Banks $E0 and $E1 decode as in R2 and R3 whatever io_inhibit is.
- R8: An access outside the window (another bank, or an offset outside $C000-$CFFF) gives rsp_hit=0, rsp_io=0, rsp_rom=0 and rsp_addr equal to the request address.
- R9: A write that decodes to ROM raises rsp_wr_drop. rsp_wr_drop is 0 for reads and for every non-ROM target.
- R10: rsp_shadow_wr is 1 only for a valid write with shadow_req=1 whose target is neither I/O nor ROM. I/O wins over shadowing.
- R11: rsp_vld is req_vld delayed by one clock. When no request was accepted, rsp_wr_drop and rsp_shadow_wr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Access request valid |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | CPU address {bank, offset} |
| slot_rom_en | input | 4 | Per-range ROM enables (see R3) |
| io_inhibit | input | 1 | Turns the low-bank window into RAM |
| aux_rd | input | 1 | Bank $00 reads from auxiliary RAM when inhibited |
| aux_wr | input | 1 | Bank $00 writes to auxiliary RAM when inhibited |
| shadow_req | input | 1 | Page-level shadowing requested for this access |
| rsp_vld | output | 1 | Result valid |
| rsp_hit | output | 1 | Access fell in the window |
| rsp_io | output | 1 | Target is internal I/O |
| rsp_rom | output | 1 | Target is internal ROM |
| rsp_addr | output | 24 | Physical address |
| rsp_wr_drop | output | 1 | Write to ROM, to be discarded |
| rsp_shadow_wr | output | 1 | Generate a shadow write |

## Verification
A wrong range boundary or a swapped enable bit shows at the ports one clock after the request. The access then reports I/O where ROM was due, or the reverse, and rsp_addr keeps its CPU bank instead of taking the top ROM bank. A bad inhibit or auxiliary routing shows up as a wrong physical bank in that same response. A broken precedence rule shows up as a shadow-write strobe or a missing drop strobe. Because the block holds no state beyond one pipeline stage, every defect is visible in the response to the request that triggers it.

// File: rtl/io_window_pkg.sv
package io_window_pkg;

    localparam int BANK_W = 8;
    localparam int OFF_W  = 16;
    localparam int ADDR_W = BANK_W + OFF_W;
    localparam int SLOT_N = 4;

    // Page (offset bits 11:8) bounds of each slot range inside the window.
    function automatic int slot_first_page(input int idx);
        case (idx)
            0:       return 1;
            1:       return 3;
            2:       return 4;
            default: return 8;
        endcase
    endfunction

    function automatic int slot_last_page(input int idx);
        case (idx)
            0:       return 2;
            1:       return 3;
            2:       return 7;
            default: return 15;
        endcase
    endfunction

    typedef enum logic [1:0] {
        TGT_MISS = 2'd0,
        TGT_IO   = 2'd1,
        TGT_ROM  = 2'd2,
        TGT_RAM  = 2'd3
    } tgt_e;

    typedef struct packed {
        logic              vld;
        logic              hit;
        logic              io;
        logic              rom;
        logic [ADDR_W-1:0] addr;
        logic              wr_drop;
        logic              shadow_wr;
    } rsp_s;

endpackage

// File: rtl/io_window_range.sv
module io_window_range
    import io_window_pkg::*;
#(
    parameter int N_SLOT = SLOT_N
) (
    input  logic [OFF_W-1:0]  off,
    output logic              in_window,
    output logic              io_page,
    output logic [N_SLOT-1:0] slot_match
);
    localparam logic [3:0] WIN_NIBBLE = 4'hC;

    logic [3:0] page;

    always_comb begin
        page      = off[11:8];
        in_window = (off[15:12] == WIN_NIBBLE);
        io_page   = in_window && (page == 4'h0);
    end

    for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
        localparam logic [3:0] LO = 4'(slot_first_page(g));
        localparam logic [3:0] HI = 4'(slot_last_page(g));
        assign slot_match[g] = in_window && (page >= LO) && (page <= HI);
    end

    always_comb begin
        if (in_window) begin
            a_one_range: assert ($onehot({io_page, slot_match}))
                else $error("window offset decodes to other than one range");
        end
    end
endmodule

// File: rtl/io_window_route.sv
module io_window_route
    import io_window_pkg::*;
#(
    parameter logic [BANK_W-1:0] ROM_TOP_BANK = 8'hFF,
    parameter logic [BANK_W-1:0] MAIN_BANK    = 8'h00,
    parameter logic [BANK_W-1:0] AUX_BANK     = 8'h01,
    parameter logic [BANK_W-1:0] LOW_BANK0    = 8'h00,
    parameter logic [BANK_W-1:0] LOW_BANK1    = 8'h01,
    parameter logic [BANK_W-1:0] HIGH_BANK0   = 8'hE0,
    parameter logic [BANK_W-1:0] HIGH_BANK1   = 8'hE1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [SLOT_N-1:0] slot_en,
    input  logic              inhibit,
    input  logic              aux_rd,
    input  logic              aux_wr,
    output tgt_e              tgt,
    output logic [ADDR_W-1:0] phys
);
    logic [BANK_W-1:0] bank;
    logic [OFF_W-1:0]  off;
    logic              in_win, io_page;
    logic [SLOT_N-1:0] slot_match;
    logic              low_bank, high_bank, aux_sel, rom_on;

    assign bank = addr[ADDR_W-1:OFF_W];
    assign off  = addr[OFF_W-1:0];

    io_window_range #(.N_SLOT(SLOT_N)) u_range (
        .off        (off),
        .in_window  (in_win),
        .io_page    (io_page),
        .slot_match (slot_match)
    );

    always_comb begin
        low_bank  = (bank == LOW_BANK0) || (bank == LOW_BANK1);
        high_bank = (bank == HIGH_BANK0) || (bank == HIGH_BANK1);
        aux_sel   = wr ? aux_wr : aux_rd;
        rom_on    = |(slot_match & slot_en);
        tgt       = TGT_MISS;
        phys      = addr;
        if (!in_win || !(low_bank || high_bank)) begin
            tgt  = TGT_MISS;
            phys = addr;
        end else if (inhibit && low_bank) begin
            tgt = TGT_RAM;
            if (bank == LOW_BANK0)
                phys = {(aux_sel ? AUX_BANK : MAIN_BANK), off};
            else
                phys = {MAIN_BANK, off};
        end else if (io_page || !rom_on) begin
            tgt  = TGT_IO;
            phys = addr;
        end else begin
            tgt  = TGT_ROM;
            phys = {ROM_TOP_BANK, off};
        end
    end

    always_comb begin
        if (inhibit && low_bank && in_win) begin
            a_inhibit_ram_r4: assert (tgt == TGT_RAM)
                else $error("inhibited low bank not decoded as RAM");
        end
    end
endmodule

// File: rtl/io_window_dec.sv
module io_window_dec
    import io_window_pkg::*;
#(
    parameter logic [BANK_W-1:0] ROM_TOP_BANK = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic              req_wr,
    input  logic [23:0]       req_addr,
    input  logic [3:0]        slot_rom_en,
    input  logic              io_inhibit,
    input  logic              aux_rd,
    input  logic              aux_wr,
    input  logic              shadow_req,
    output logic              rsp_vld,
    output logic              rsp_hit,
    output logic              rsp_io,
    output logic              rsp_rom,
    output logic [23:0]       rsp_addr,
    output logic              rsp_wr_drop,
    output logic              rsp_shadow_wr
);
    tgt_e              tgt;
    logic [ADDR_W-1:0] phys;
    rsp_s              rsp_d, rsp_q;

    io_window_route #(.ROM_TOP_BANK(ROM_TOP_BANK)) u_route (
        .addr    (req_addr),
        .wr      (req_wr),
        .slot_en (slot_rom_en),
        .inhibit (io_inhibit),
        .aux_rd  (aux_rd),
        .aux_wr  (aux_wr),
        .tgt     (tgt),
        .phys    (phys)
    );

    always_comb begin
        rsp_d           = '0;
        rsp_d.vld       = req_vld;
        rsp_d.hit       = (tgt != TGT_MISS);
        rsp_d.io        = (tgt == TGT_IO);
        rsp_d.rom       = (tgt == TGT_ROM);
        rsp_d.addr      = phys;
        rsp_d.wr_drop   = req_vld && req_wr && (tgt == TGT_ROM);
        rsp_d.shadow_wr = req_vld && req_wr && shadow_req
                          && (tgt != TGT_IO) && (tgt != TGT_ROM);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_vld       = rsp_q.vld;
    assign rsp_hit       = rsp_q.hit;
    assign rsp_io        = rsp_q.io;
    assign rsp_rom       = rsp_q.rom;
    assign rsp_addr      = rsp_q.addr;
    assign rsp_wr_drop   = rsp_q.wr_drop;
    assign rsp_shadow_wr = rsp_q.shadow_wr;

    p_io_rom_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_io && rsp_rom));
    p_miss_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (!rsp_io && !rsp_rom));
    p_drop_only_rom_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wr_drop |-> (rsp_rom && rsp_vld));
    p_shadow_not_io_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_shadow_wr |-> (!rsp_io && !rsp_rom));
    p_rsp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld);
    p_rom_top_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rom |-> (rsp_addr[23:16] == ROM_TOP_BANK));
endmodule

// File: tb/io_window_dec_test.sv
module io_window_dec_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0, req_wr = 1'b0;
    logic [23:0] req_addr = '0;
    logic [3:0]  slot_rom_en = '0;
    logic        io_inhibit = 1'b0, aux_rd = 1'b0, aux_wr = 1'b0, shadow_req = 1'b0;
    logic        rsp_vld, rsp_hit, rsp_io, rsp_rom, rsp_wr_drop, rsp_shadow_wr;
    logic [23:0] rsp_addr;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    io_window_dec uut (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
        .req_addr(req_addr), .slot_rom_en(slot_rom_en), .io_inhibit(io_inhibit),
        .aux_rd(aux_rd), .aux_wr(aux_wr), .shadow_req(shadow_req),
        .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_io(rsp_io), .rsp_rom(rsp_rom),
        .rsp_addr(rsp_addr), .rsp_wr_drop(rsp_wr_drop), .rsp_shadow_wr(rsp_shadow_wr)
    );

    // {req, addr, wr, slots, inh, auxr, auxw, shreq, hit, io, rom, eaddr, drop, shw}
    localparam int VW = 4 + 24 + 1 + 4 + 4 + 3 + 24 + 2;
    localparam int NV = 22;
    localparam logic [VW-1:0] VEC [NV] = '{
        {4'd2, 24'h00C030,1'b0,4'h0,4'b0000, 3'b110,24'h00C030,2'b00}, // R2
        {4'd3, 24'h00C150,1'b0,4'h1,4'b0000, 3'b101,24'hFFC150,2'b00}, // R3
        {4'd3, 24'h00C2FF,1'b0,4'h1,4'b0000, 3'b101,24'hFFC2FF,2'b00}, // R3
        {4'd3, 24'h00C300,1'b0,4'h1,4'b0000, 3'b110,24'h00C300,2'b00}, // R3
        {4'd3, 24'h01C3FF,1'b0,4'h2,4'b0000, 3'b101,24'hFFC3FF,2'b00}, // R3
        {4'd3, 24'hE0C400,1'b0,4'h4,4'b0000, 3'b101,24'hFFC400,2'b00}, // R3
        {4'd3, 24'hE1C7FF,1'b0,4'h3,4'b0000, 3'b110,24'hE1C7FF,2'b00}, // R3
        {4'd3, 24'h00CFFF,1'b0,4'h8,4'b0000, 3'b101,24'hFFCFFF,2'b00}, // R3
        {4'd3, 24'h00C800,1'b0,4'h7,4'b0000, 3'b110,24'h00C800,2'b00}, // R3
        {4'd4, 24'h00C030,1'b0,4'hF,4'b1000, 3'b100,24'h00C030,2'b00}, // R4
        {4'd5, 24'h00C500,1'b0,4'hF,4'b1100, 3'b100,24'h01C500,2'b00}, // R5
        {4'd5, 24'h00C500,1'b1,4'h0,4'b1010, 3'b100,24'h01C500,2'b00}, // R5
        {4'd5, 24'h00C500,1'b1,4'h0,4'b1100, 3'b100,24'h00C500,2'b00}, // R5
        {4'd6, 24'h01C900,1'b0,4'hF,4'b1110, 3'b100,24'h00C900,2'b00}, // R6
        {4'd7, 24'hE0C030,1'b0,4'h0,4'b1000, 3'b110,24'hE0C030,2'b00}, // R7
        {4'd7, 24'hE1C900,1'b0,4'h8,4'b1000, 3'b101,24'hFFC900,2'b00}, // R7
        {4'd8, 24'h02C030,1'b0,4'hF,4'b0000, 3'b000,24'h02C030,2'b00}, // R8
        {4'd8, 24'h00BFFF,1'b0,4'hF,4'b0000, 3'b000,24'h00BFFF,2'b00}, // R8
        {4'd9, 24'h00C150,1'b1,4'h1,4'b0001, 3'b101,24'hFFC150,2'b10}, // R9
        {4'd10,24'h00C030,1'b1,4'h0,4'b0001, 3'b110,24'h00C030,2'b00}, // R10
        {4'd10,24'h00C500,1'b1,4'h0,4'b1001, 3'b100,24'h00C500,2'b01}, // R10
        {4'd10,24'h02C030,1'b1,4'h0,4'b0001, 3'b000,24'h02C030,2'b01}  // R10
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog expired act=running exp=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 outputs", {25'd0, rsp_vld, rsp_hit, rsp_io, rsp_rom, rsp_wr_drop, rsp_shadow_wr}, 32'd0);
        check("R1 addr", {8'd0, rsp_addr}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {26'd0, rsp_vld, rsp_io, rsp_rom, rsp_wr_drop, rsp_shadow_wr, rsp_hit}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            string tag;
            v = VEC[i];
            req_vld     = 1'b1;
            req_addr    = v[VW-5 -: 24];
            req_wr      = v[VW-29];
            slot_rom_en = v[VW-30 -: 4];
            io_inhibit  = v[VW-34];
            aux_rd      = v[VW-35];
            aux_wr      = v[VW-36];
            shadow_req  = v[VW-37];
            @(negedge clk);
            tag = $sformatf("R%0d vec%0d", v[VW-1 -: 4], i);
            check({tag, " class"}, {28'd0, rsp_vld, rsp_hit, rsp_io, rsp_rom}, {28'd0, 1'b1, v[28:26]});
            check({tag, " addr"}, {8'd0, rsp_addr}, {8'd0, v[25:2]});
            check({tag, " strobes"}, {30'd0, rsp_wr_drop, rsp_shadow_wr}, {30'd0, v[1:0]});
        end

        // R11: no request -> no strobes, vld low
        req_vld = 1'b0; req_wr = 1'b1; shadow_req = 1'b1;
        req_addr = 24'h00C150; slot_rom_en = 4'h1; io_inhibit = 1'b0;
        @(negedge clk);
        check("R11 idle strobes", {29'd0, rsp_vld, rsp_wr_drop, rsp_shadow_wr}, 32'd0);
        // R11: one-cycle latency; response not visible before the edge
        req_vld = 1'b1; req_wr = 1'b0; req_addr = 24'h00C030;
        #1;
        check("R11 before edge", {31'd0, rsp_vld}, 32'd0);
        @(negedge clk);
        check("R11 after edge", {30'd0, rsp_vld, rsp_io}, 32'd3);
        req_vld = 1'b0;
        @(negedge clk);
        check("R11 drop vld", {31'd0, rsp_vld}, 32'd0);
        // R7: high bank ROM write dropped under inhibit
        req_vld = 1'b1; req_wr = 1'b1; req_addr = 24'hE1CC00; slot_rom_en = 4'h8;
        io_inhibit = 1'b1; shadow_req = 1'b1;
        @(negedge clk);
        check("R7 rom write under inhibit", {29'd0, rsp_rom, rsp_wr_drop, rsp_shadow_wr}, 32'd6);
        // R1: reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 re-reset", {27'd0, rsp_vld, rsp_hit, rsp_rom, rsp_wr_drop, rsp_shadow_wr}, 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule